// File: doc/BRIEF.md
# Line Level Serializer

Once per video line this block runs a 6-bit successive-approximation conversion of an externally held analog level and sends the result out serially. The held level is the line integral of the strongest colour component. An external DAC and comparator sit outside the block. The block drives the DAC with a trial code and reads back one comparator decision per clock.

A horizontal-drive strobe samples the white-peak flag and starts the conversion. When the sixth decision is made, the block emits a 7-bit word. The word carries the level code MSB first and then the peak flag. A valid strobe is high during those seven bit times. The code scale runs from light to dark: a line that is fully white gives code 0, and a line that is fully black gives the top code. The word appears after the line it describes, so it trails the video by one line period.

The comparator input reads 1 when the held level is at least as dark as the level that the current trial code represents.

Top module: `line_level_serializer`

## Requirements
- R1: While reset is asserted, `dac_code` is 0, `word_valid` is 0 and `ser_data` is 0.
- R2: On the clock after a cycle with `hd_strobe` high, `dac_code` equals the half-scale trial: only the MSB (bit 5) is set, value 32.
- R3: On each of the 6 clocks after the strobe, the bit under test is kept when `cmp_keep` is 1 and cleared when it is 0. The next lower bit is then set to 1. After the sixth decision no further bit is set.
- R4: When the comparator is a monotone model of a darkness level D in 0..63, the final `dac_code` equals D. A white line (D=0) gives 0x00 and a black line (D=63) gives 0x3F.
- R5: The peak flag sent in a word is the value of `peak_in` in the strobe cycle. Changes of `peak_in` after the strobe have no effect on that word.
- R6: On the clock of the sixth decision, `word_valid` rises and stays high for exactly 7 cycles. `ser_data` carries code bits 5 down to 0, and then the peak flag as the seventh bit. `ser_data` is 0 whenever `word_valid` is 0.
- R7: A strobe that arrives during a conversion or during a word aborts it. `word_valid` is 0 on the next cycle, and a fresh conversion starts at the half-scale trial.
- R8: Outside the six decision clocks, `cmp_keep` has no effect. `dac_code` keeps the last result until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_strobe | input | 1 | One-cycle horizontal-drive start pulse |
| cmp_keep | input | 1 | Comparator: held level at least as dark as trial |
| peak_in | input | 1 | White-peak detector flag for the line |
| dac_code | output | CODE_W | Trial code to the external DAC |
| ser_data | output | 1 | Serial word, MSB first, peak flag last |
| word_valid | output | 1 | High while the 7 word bits are shifted |

## Verification
The bench builds the block with the default code width of 6, so the word is 7 bits wide and there are 64 levels. At that size every darkness level from white to black can be swept. The bench checks each trial step of every sweep against a comparator model, and checks each serial bit, including the extremes 0x00 and 0x3F. The small code space also makes it cheap to place an abort strobe inside both the decision phase and the shift phase, and to check that the next word is still correct.

// File: rtl/lls_pkg.sv
package lls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } lls_state_e;
endpackage

// File: rtl/lls_rst_sync.sv
module lls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lls_ctrl.sv
module lls_ctrl
  import lls_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hd_strobe,
  output logic sar_start,
  output logic sar_step,
  output logic sh_load,
  output logic sh_shift,
  output logic sh_last,
  output logic sh_abort
);
  localparam int WORD_W = CODE_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  lls_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sar_start = hd_strobe;
    sh_abort  = hd_strobe;
    sar_step  = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    sh_last   = 1'b0;
    if (hd_strobe) begin
      state_d = ST_CONV;
      cnt_d   = CNT_W'(CODE_W - 1);
    end else begin
      case (state_q)
        ST_CONV: begin
          sar_step = 1'b1;
          if (cnt_q == '0) begin
            sh_load = 1'b1;
            state_d = ST_SHIFT;
            cnt_d   = CNT_W'(WORD_W - 1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          sh_shift = 1'b1;
          sh_last  = (cnt_q == '0);
          if (cnt_q == '0) state_d = ST_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8: the idle state is left only through a strobe
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !hd_strobe) |=> (state_q == ST_IDLE));

  // R6: the final shift returns the controller to idle
  p_word_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_shift && sh_last) |=> (state_q == ST_IDLE && !sar_step));
endmodule

// File: rtl/lls_sar_core.sv
module lls_sar_core #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              cmp_keep,
  output logic [CODE_W-1:0] trial,
  output logic [CODE_W-1:0] decided
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  logic [CODE_W-1:0] ptr_q, ptr_d, trial_d, above_mask;
  logic              upd_en;

  always_comb begin
    decided = trial;
    for (int b = 0; b < CODE_W; b++) begin
      if (ptr_q[b] && !cmp_keep) decided[b] = 1'b0;
    end
  end

  always_comb begin
    upd_en  = start | step;
    trial_d = trial;
    ptr_d   = ptr_q;
    if (start) begin
      trial_d = MSB_ONLY;
      ptr_d   = MSB_ONLY;
    end else if (step) begin
      trial_d = decided | (ptr_q >> 1);
      ptr_d   = ptr_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial <= '0;
      ptr_q <= '0;
    end else if (upd_en) begin
      trial <= trial_d;
      ptr_q <= ptr_d;
    end
  end

  assign above_mask = ~((ptr_q << 1) - ONE);

  // R2: a start always loads the half-scale trial
  p_start_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (trial == MSB_ONLY));

  // R3: a decision never disturbs bits already decided above the pointer
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start) |=> (((trial ^ $past(trial)) & $past(above_mask)) == '0));

  // R8: without start or step the code is frozen
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> $stable(trial));
endmodule

// File: rtl/lls_shifter.sv
module lls_shifter #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              last,
  input  logic              abort,
  input  logic [CODE_W-1:0] code,
  input  logic              peak,
  output logic              ser,
  output logic              valid
);
  localparam int WORD_W = CODE_W + 1;

  logic [WORD_W-1:0] sh_q, sh_d;
  logic              v_d, sh_en;

  always_comb begin
    sh_en = abort | load | shift;
    sh_d  = sh_q;
    v_d   = valid;
    if (abort) begin
      v_d = 1'b0;
    end else if (load) begin
      sh_d = {code, peak};
      v_d  = 1'b1;
    end else if (shift) begin
      sh_d = sh_q << 1;
      v_d  = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      valid <= 1'b0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      valid <= v_d;
    end
  end

  assign ser = valid & sh_q[WORD_W-1];

  // R6: a load opens the word with the code MSB on the line
  p_load_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) |=> (valid && ser == $past(code[CODE_W-1])));

  // R7: an abort closes any word at once
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!valid && !ser));
endmodule

// File: rtl/line_level_serializer.sv
module line_level_serializer #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd_strobe,
  input  logic              cmp_keep,
  input  logic              peak_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              ser_data,
  output logic              word_valid
);
  logic              rst_n_s;
  logic              sar_start, sar_step;
  logic              sh_load, sh_shift, sh_last, sh_abort;
  logic              peak_q;
  logic [CODE_W-1:0] decided;

  lls_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  lls_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hd_strobe (hd_strobe),
    .sar_start (sar_start),
    .sar_step  (sar_step),
    .sh_load   (sh_load),
    .sh_shift  (sh_shift),
    .sh_last   (sh_last),
    .sh_abort  (sh_abort)
  );

  lls_sar_core #(.CODE_W(CODE_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (sar_start),
    .step     (sar_step),
    .cmp_keep (cmp_keep),
    .trial    (dac_code),
    .decided  (decided)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       peak_q <= 1'b0;
    else if (hd_strobe) peak_q <= peak_in;
  end

  lls_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (sh_load),
    .shift (sh_shift),
    .last  (sh_last),
    .abort (sh_abort),
    .code  (decided),
    .peak  (peak_q),
    .ser   (ser_data),
    .valid (word_valid)
  );

  // R5: the captured peak flag changes only at a strobe
  p_peak_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hd_strobe |=> $stable(peak_q));

  // R7: a strobe restarts at half scale with no word on the line
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    hd_strobe |=> (!word_valid && dac_code == {1'b1, {(CODE_W-1){1'b0}}}));
endmodule

// File: tb/line_level_serializer_test.sv
module line_level_serializer_test;
  logic       clk;
  logic       rst_n;
  logic       hd_strobe;
  logic       peak_in;
  logic       cmp_keep;
  logic [5:0] dac_code;
  logic       ser_data;
  logic       word_valid;

  int  dark_q;
  int  n_checks;
  int  n_errors;
  bit  done;

  line_level_serializer #(.CODE_W(6)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hd_strobe  (hd_strobe),
    .cmp_keep   (cmp_keep),
    .peak_in    (peak_in),
    .dac_code   (dac_code),
    .ser_data   (ser_data),
    .word_valid (word_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // comparator model: keep when the held darkness is at least the trial
  assign cmp_keep = (int'(dac_code) <= dark_q);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hd_strobe = 1'b0; peak_in = 1'b0; dark_q = 0;
    repeat (3) @(negedge clk);
    chk(dac_code == 6'd0, "R1 dac_code", dac_code, 0);
    chk(word_valid == 1'b0, "R1 word_valid", word_valid, 0);
    chk(ser_data == 1'b0, "R1 ser_data", ser_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one full line: strobe, six decisions, seven serial bits
  task automatic run_line(input int dark, input bit pk, input bit flip);
    int exp_code;
    int bitm;
    dark_q = dark;
    @(negedge clk);
    hd_strobe = 1'b1; peak_in = pk;
    @(negedge clk);
    hd_strobe = 1'b0;
    if (flip) peak_in = !pk;
    chk(dac_code == 6'd32, "R2 half-scale trial", dac_code, 32);
    chk(word_valid == 1'b0, "R7 no word after strobe", word_valid, 0);
    exp_code = 32;
    bitm = 32;
    for (int k = 0; k < 6; k++) begin
      if (!(exp_code <= dark)) exp_code = exp_code & ~bitm;
      bitm = bitm >> 1;
      exp_code = exp_code | bitm;
      @(negedge clk);
      chk(int'(dac_code) == exp_code, "R3 trial step", dac_code, exp_code);
    end
    chk(int'(dac_code) == dark, "R4 final code", dac_code, dark);
    for (int i = 0; i < 7; i++) begin
      int eb;
      eb = (i < 6) ? ((dark >> (5 - i)) & 1) : int'(pk);
      chk(word_valid == 1'b1, "R6 valid during word", word_valid, 1);
      if (i < 6) chk(int'(ser_data) == eb, "R6 code bit", ser_data, eb);
      else       chk(int'(ser_data) == eb, "R5 peak bit", ser_data, eb);
      @(negedge clk);
    end
    chk(word_valid == 1'b0, "R6 valid drops after 7", word_valid, 0);
    chk(ser_data == 1'b0, "R6 ser low when idle", ser_data, 0);
  endtask

  task automatic t_extremes();
    run_line(0, 1'b1, 1'b0);   // white line, R4
    run_line(63, 1'b0, 1'b0);  // black line, R4
  endtask

  task automatic t_sweep();
    for (int d = 0; d < 64; d++) run_line(d, d[0], d[1]);
  endtask

  task automatic t_idle_ignore();
    run_line(43, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      dark_q = (i % 2 == 0) ? 0 : 63;
      @(negedge clk);
      chk(dac_code == 6'd43, "R8 code held in idle", dac_code, 43);
      chk(word_valid == 1'b0, "R8 no word in idle", word_valid, 0);
    end
  endtask

  task automatic t_abort_conv();
    dark_q = 10;
    @(negedge clk); hd_strobe = 1'b1; peak_in = 1'b1;
    @(negedge clk); hd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    run_line(50, 1'b0, 1'b1);  // R7 restart mid-conversion
  endtask

  task automatic t_abort_shift();
    dark_q = 21;
    @(negedge clk); hd_strobe = 1'b1; peak_in = 1'b0;
    @(negedge clk); hd_strobe = 1'b0;
    repeat (8) @(negedge clk);
    chk(word_valid == 1'b1, "R7 word in progress", word_valid, 1);
    run_line(7, 1'b1, 1'b0);   // R7 restart mid-word
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    t_reset();
    t_extremes();
    t_sweep();
    t_idle_ignore();
    t_abort_conv();
    t_abort_shift();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule